// File: doc/BRIEF.md
# USB2 PHY Power-Up Sequencer

This block brings a two-port USB2 PHY out of power-down and puts it back again under timed control. It owns the reference-clock enable, a power-on reset shared by both ports, and one UTMI reset per port. Every reset output is active low. During the first bring-up it makes one configuration write through the PHY's test-register port. That write turns on the PHY's internal clock.

Each port has an init request pulse and an exit request pulse. The sequencer queues these requests and serves them one at a time. If the shared resources are already up, a port init only releases that port's UTMI reset. If a port exit leaves no port active, the sequencer also takes down the shared resources. All settle times are given in microseconds and converted to system-clock cycles from the `CLK_HZ` parameter.

The states are:
- `ST_IDLE`: waits for a granted request.
- `ST_CLK_WAIT`: reference-clock settle time.
- `ST_POR_WAIT`: settle time after the power-on reset is released.
- `ST_CFG_WRITE`: holds the write request until the done handshake arrives.
- `ST_CFG_WAIT`: PHY-clock settle time.
- `ST_UTMI_WAIT`: port reset completion time.
- `ST_DOWN_POR`: asserts the power-on reset during shutdown.
- `ST_DOWN_CLK`: gates the reference clock during shutdown.

The transitions are:
- `ST_IDLE` to `ST_CLK_WAIT`: cold init.
- `ST_IDLE` to `ST_UTMI_WAIT`: warm init.
- `ST_IDLE` to `ST_IDLE`: exit of a port while another port stays up.
- `ST_IDLE` to `ST_DOWN_POR`: exit of the last active port.
- `ST_CLK_WAIT` to `ST_POR_WAIT` to `ST_CFG_WRITE` to `ST_CFG_WAIT` to `ST_UTMI_WAIT` to `ST_IDLE`: the cold bring-up chain.
- `ST_DOWN_POR` to `ST_DOWN_CLK` to `ST_IDLE`: the shutdown chain.

Top module: `usb_phy_pwrseq`

## Requirements
- R1: After reset, these outputs are all 0: `refclk_en`, `por_rst_n`, every bit of `utmi_rst_n`, `port_ready`, and `cfg_wr_req`.
- R2: A cold init raises `refclk_en` first. `por_rst_n` then rises exactly T_REF cycles later, where T_REF is 100 us in cycles. `por_rst_n` is never high while `refclk_en` is low.
- R3: `cfg_wr_req` rises exactly T_POR cycles after `por_rst_n` rises, where T_POR is 300 us in cycles. While `cfg_wr_req` is high, it presents port 0, address 0x06 and data 0x04, with all UTMI resets still asserted.
- R4: `cfg_wr_req` stays high until `cfg_wr_done` is sampled high, and falls on that edge. The requesting port's UTMI reset is released exactly T_PHY cycles later, where T_PHY is 2 ms in cycles.
- R5: Only the requesting port's UTMI reset is released. Its `port_ready` bit rises exactly T_UTMI cycles after that release, where T_UTMI is 2 ms in cycles. No UTMI reset is high while `por_rst_n` is low.
- R6: An init on a port while the shared resources are up releases only that port's UTMI reset, within 3 cycles of the request. It makes no configuration write, and `port_ready` follows after T_UTMI cycles.
- R7: An exit while another port remains ready asserts that port's UTMI reset and clears its ready bit. The shared clock and power-on reset stay up.
- R8: An exit of the last ready port asserts its UTMI reset first. `por_rst_n` falls one cycle later, and `refclk_en` falls one cycle after that.
- R9: Requests that arrive while a sequence is running are held, then served once the sequencer is idle. Among pending ports, port 0 goes first. A held warm init releases its UTMI reset one cycle after the previous port becomes ready.
- R10: An init for a port that is already ready has no effect on any output. An exit for a port that is not ready has no effect on any output.
- R11: A set `port_ready` bit implies three things: that port's UTMI reset is released, `por_rst_n` is high, and `refclk_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_req | input | NUM_PORTS | Per-port bring-up request pulse |
| exit_req | input | NUM_PORTS | Per-port shutdown request pulse |
| refclk_en | output | 1 | Reference clock enable |
| por_rst_n | output | 1 | Shared power-on reset, active low |
| utmi_rst_n | output | NUM_PORTS | Per-port UTMI reset, active low |
| cfg_wr_req | output | 1 | Test-register write request, held until done |
| cfg_wr_port | output | PORT_W | Target port of the write |
| cfg_wr_addr | output | ADDR_W | Register address of the write |
| cfg_wr_data | output | DATA_W | Write data |
| cfg_wr_done | input | 1 | Write completion from the test-register port |
| port_ready | output | NUM_PORTS | Per-port ready flag |

## Verification
The bench times-stamps every edge of every output and checks each settle interval to the exact cycle. An off-by-one reload of the down-counter would show up as an interval one cycle short or long. It holds back the write completion for several cycles, which catches a design that lets the write request drop or starts the PHY-clock settle time early. It repeats an init on a port that is already up and checks that no second configuration write is made and that the shared stages are not rerun. It also checks that a shutdown of one port leaves the other port's power intact, while a shutdown of the last port follows the reset-then-clock order cycle by cycle. Finally, it pulses both init requests on the same cycle, so a design that dropped the held request or served port 1 first fails the ordering check.

// File: rtl/usb_pwrseq_pkg.sv
package usb_pwrseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLK_WAIT,
        ST_POR_WAIT,
        ST_CFG_WRITE,
        ST_CFG_WAIT,
        ST_UTMI_WAIT,
        ST_DOWN_POR,
        ST_DOWN_CLK
    } seq_state_e;

    // Convert microseconds to clock cycles; never below one cycle.
    function automatic longint unsigned us_to_cycles(longint unsigned clk_hz,
                                                     longint unsigned usec);
        longint unsigned cyc;
        cyc = (clk_hz * usec) / 64'd1_000_000;
        if (cyc == 0) cyc = 1;
        return cyc;
    endfunction

    function automatic longint unsigned max2(longint unsigned a, longint unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pwrseq_timer.sv
// Down-counter reloaded on every state entry; expired once it reaches zero.
module pwrseq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/pwrseq_req_arb.sv
// Holds per-port init/exit requests and grants the lowest-numbered valid one.
module pwrseq_req_arb #(
    parameter int NUM_PORTS = 2,
    parameter int PORT_W    = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] init_req,
    input  logic [NUM_PORTS-1:0] exit_req,
    input  logic [NUM_PORTS-1:0] port_up,
    input  logic                 seq_idle,
    input  logic                 take,
    output logic                 grant_vld,
    output logic [PORT_W-1:0]    grant_port,
    output logic                 grant_is_init
);

    logic [NUM_PORTS-1:0] pend_init_q, pend_exit_q;
    logic [NUM_PORTS-1:0] v_init, v_exit;
    logic [NUM_PORTS-1:0] clr_init, clr_exit;
    logic [NUM_PORTS-1:0] grant_oh;

    // An init is only meaningful for a port that is down, an exit for one that is up.
    assign v_init = pend_init_q & ~port_up;
    assign v_exit = pend_exit_q &  port_up;

    always_comb begin
        grant_vld     = 1'b0;
        grant_port    = '0;
        grant_is_init = 1'b0;
        for (int p = NUM_PORTS - 1; p >= 0; p--) begin
            if (v_init[p] || v_exit[p]) begin
                grant_vld     = 1'b1;
                grant_port    = PORT_W'(p);
                grant_is_init = v_init[p];
            end
        end
    end

    assign grant_oh = NUM_PORTS'(1) << grant_port;

    always_comb begin
        clr_init = '0;
        clr_exit = '0;
        if (seq_idle) begin
            clr_init = pend_init_q & port_up;
            clr_exit = pend_exit_q & ~port_up;
        end
        if (take) begin
            if (grant_is_init) clr_init = clr_init | grant_oh;
            else               clr_exit = clr_exit | grant_oh;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_init_q <= '0;
            pend_exit_q <= '0;
        end else begin
            pend_init_q <= (pend_init_q & ~clr_init) | init_req;
            pend_exit_q <= (pend_exit_q & ~clr_exit) | exit_req;
        end
    end

endmodule

// File: rtl/usb_phy_pwrseq.sv
module usb_phy_pwrseq
    import usb_pwrseq_pkg::*;
#(
    parameter longint unsigned CLK_HZ    = 100_000_000,
    parameter int              NUM_PORTS = 2,
    parameter int              PORT_W    = 3,
    parameter int              ADDR_W    = 8,
    parameter int              DATA_W    = 8,
    parameter int              CFG_PORT  = 0,
    parameter int              CFG_ADDR  = 'h06,
    parameter int              CFG_DATA  = 'h04,
    parameter longint unsigned REF_US    = 100,
    parameter longint unsigned POR_US    = 300,
    parameter longint unsigned PHY_US    = 2000,
    parameter longint unsigned UTMI_US   = 2000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] init_req,
    input  logic [NUM_PORTS-1:0] exit_req,
    output logic                 refclk_en,
    output logic                 por_rst_n,
    output logic [NUM_PORTS-1:0] utmi_rst_n,
    output logic                 cfg_wr_req,
    output logic [PORT_W-1:0]    cfg_wr_port,
    output logic [ADDR_W-1:0]    cfg_wr_addr,
    output logic [DATA_W-1:0]    cfg_wr_data,
    input  logic                 cfg_wr_done,
    output logic [NUM_PORTS-1:0] port_ready
);

    localparam longint unsigned T_REF  = us_to_cycles(CLK_HZ, REF_US);
    localparam longint unsigned T_POR  = us_to_cycles(CLK_HZ, POR_US);
    localparam longint unsigned T_PHY  = us_to_cycles(CLK_HZ, PHY_US);
    localparam longint unsigned T_UTMI = us_to_cycles(CLK_HZ, UTMI_US);
    localparam longint unsigned T_MAX  = max2(max2(T_REF, T_POR), max2(T_PHY, T_UTMI));
    localparam int              CNT_W  = $clog2(T_MAX + 1);

    seq_state_e state_q, state_nxt;

    logic                 shared_up_q;
    logic [PORT_W-1:0]    cur_port_q;
    logic                 take;
    logic                 grant_vld, grant_is_init;
    logic [PORT_W-1:0]    grant_port;
    logic [NUM_PORTS-1:0] grant_oh;
    logic                 others_up;
    logic                 tmr_load, tmr_expired;
    logic [CNT_W-1:0]     tmr_val;

    assign grant_oh  = NUM_PORTS'(1) << grant_port;
    assign others_up = |(port_ready & ~grant_oh);

    pwrseq_req_arb #(
        .NUM_PORTS (NUM_PORTS),
        .PORT_W    (PORT_W)
    ) u_arb (
        .clk           (clk),
        .rst_n         (rst_n),
        .init_req      (init_req),
        .exit_req      (exit_req),
        .port_up       (port_ready),
        .seq_idle      (state_q == ST_IDLE),
        .take          (take),
        .grant_vld     (grant_vld),
        .grant_port    (grant_port),
        .grant_is_init (grant_is_init)
    );

    pwrseq_timer #(
        .CNT_W (CNT_W)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    // Next-state logic.
    always_comb begin
        state_nxt = state_q;
        take      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (grant_vld) begin
                    take = 1'b1;
                    if (grant_is_init) state_nxt = shared_up_q ? ST_UTMI_WAIT : ST_CLK_WAIT;
                    else               state_nxt = others_up   ? ST_IDLE      : ST_DOWN_POR;
                end
            end
            ST_CLK_WAIT:  if (tmr_expired) state_nxt = ST_POR_WAIT;
            ST_POR_WAIT:  if (tmr_expired) state_nxt = ST_CFG_WRITE;
            ST_CFG_WRITE: if (cfg_wr_done) state_nxt = ST_CFG_WAIT;
            ST_CFG_WAIT:  if (tmr_expired) state_nxt = ST_UTMI_WAIT;
            ST_UTMI_WAIT: if (tmr_expired) state_nxt = ST_IDLE;
            ST_DOWN_POR:  state_nxt = ST_DOWN_CLK;
            ST_DOWN_CLK:  state_nxt = ST_IDLE;
            default:      state_nxt = ST_IDLE;
        endcase
    end

    // Timer reload on every state entry.
    assign tmr_load = (state_nxt != state_q);

    always_comb begin
        unique case (state_nxt)
            ST_CLK_WAIT:  tmr_val = CNT_W'(T_REF  - 1);
            ST_POR_WAIT:  tmr_val = CNT_W'(T_POR  - 1);
            ST_CFG_WAIT:  tmr_val = CNT_W'(T_PHY  - 1);
            ST_UTMI_WAIT: tmr_val = CNT_W'(T_UTMI - 1);
            default:      tmr_val = '0;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nxt;
    end

    // Output register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            refclk_en   <= 1'b0;
            por_rst_n   <= 1'b0;
            utmi_rst_n  <= '0;
            port_ready  <= '0;
            cfg_wr_req  <= 1'b0;
            shared_up_q <= 1'b0;
            cur_port_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (take) begin
                        cur_port_q <= grant_port;
                        if (grant_is_init) begin
                            if (shared_up_q) utmi_rst_n[grant_port] <= 1'b1;
                            else             refclk_en <= 1'b1;
                        end else begin
                            utmi_rst_n[grant_port] <= 1'b0;
                            port_ready[grant_port] <= 1'b0;
                        end
                    end
                end
                ST_CLK_WAIT:  if (tmr_expired) por_rst_n  <= 1'b1;
                ST_POR_WAIT:  if (tmr_expired) cfg_wr_req <= 1'b1;
                ST_CFG_WRITE: if (cfg_wr_done) cfg_wr_req <= 1'b0;
                ST_CFG_WAIT: begin
                    if (tmr_expired) begin
                        utmi_rst_n[cur_port_q] <= 1'b1;
                        shared_up_q            <= 1'b1;
                    end
                end
                ST_UTMI_WAIT: if (tmr_expired) port_ready[cur_port_q] <= 1'b1;
                ST_DOWN_POR:  por_rst_n <= 1'b0;
                ST_DOWN_CLK: begin
                    refclk_en   <= 1'b0;
                    shared_up_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign cfg_wr_port = PORT_W'(CFG_PORT);
    assign cfg_wr_addr = ADDR_W'(CFG_ADDR);
    assign cfg_wr_data = DATA_W'(CFG_DATA);

endmodule

// File: rtl/usb_phy_pwrseq_chk.sv
module usb_phy_pwrseq_chk #(
    parameter int NUM_PORTS = 2,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 refclk_en,
    input logic                 por_rst_n,
    input logic [NUM_PORTS-1:0] utmi_rst_n,
    input logic                 cfg_wr_req,
    input logic                 cfg_wr_done,
    input logic [ADDR_W-1:0]    cfg_wr_addr,
    input logic [DATA_W-1:0]    cfg_wr_data,
    input logic [NUM_PORTS-1:0] port_ready
);

    // R2
    por_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        por_rst_n |-> refclk_en);

    // R3
    wr_cold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_req |-> (por_rst_n && (utmi_rst_n == '0)));

    // R3
    wr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_req && $past(cfg_wr_req)) |-> ($stable(cfg_wr_addr) && $stable(cfg_wr_data)));

    // R4
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_req && !cfg_wr_done) |=> cfg_wr_req);

    // R8
    por_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(por_rst_n) |-> (utmi_rst_n == '0));

    // R8
    clk_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(refclk_en) |-> !por_rst_n);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        // R5
        utmi_por_chk: assert property (@(posedge clk) disable iff (!rst_n)
            utmi_rst_n[p] |-> por_rst_n);

        // R11
        ready_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
            port_ready[p] |-> (utmi_rst_n[p] && por_rst_n && refclk_en));
    end

endmodule

bind usb_phy_pwrseq usb_phy_pwrseq_chk #(
    .NUM_PORTS (NUM_PORTS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .refclk_en   (refclk_en),
    .por_rst_n   (por_rst_n),
    .utmi_rst_n  (utmi_rst_n),
    .cfg_wr_req  (cfg_wr_req),
    .cfg_wr_done (cfg_wr_done),
    .cfg_wr_addr (cfg_wr_addr),
    .cfg_wr_data (cfg_wr_data),
    .port_ready  (port_ready)
);

// File: tb/usb_phy_pwrseq_tb.sv
`timescale 1ns/1ps
module usb_phy_pwrseq_tb;

    localparam int T_REF  = 100;
    localparam int T_POR  = 300;
    localparam int T_PHY  = 2000;
    localparam int T_UTMI = 2000;
    localparam int DONE_LAT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] init_req = '0;
    logic [1:0] exit_req = '0;
    logic       refclk_en, por_rst_n, cfg_wr_req;
    logic       cfg_wr_done = 1'b0;
    logic [1:0] utmi_rst_n, port_ready;
    logic [2:0] cfg_wr_port;
    logic [7:0] cfg_wr_addr, cfg_wr_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int rise_clk, fall_clk, rise_por, fall_por, rise_req, fall_req, cfg_cnt;
    int rise_utmi [2];
    int fall_utmi [2];
    int rise_rdy  [2];
    logic [2:0] cap_port;
    logic [7:0] cap_addr, cap_data;
    logic [1:0] cap_utmi;

    usb_phy_pwrseq #(
        .CLK_HZ (1_000_000)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_req    (init_req),
        .exit_req    (exit_req),
        .refclk_en   (refclk_en),
        .por_rst_n   (por_rst_n),
        .utmi_rst_n  (utmi_rst_n),
        .cfg_wr_req  (cfg_wr_req),
        .cfg_wr_port (cfg_wr_port),
        .cfg_wr_addr (cfg_wr_addr),
        .cfg_wr_data (cfg_wr_data),
        .cfg_wr_done (cfg_wr_done),
        .port_ready  (port_ready)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Edge recorder, sampled away from the active edge.
    initial begin
        logic p_clk, p_por, p_req;
        logic [1:0] p_utmi, p_rdy;
        p_clk = 0; p_por = 0; p_req = 0; p_utmi = 0; p_rdy = 0;
        cfg_cnt = 0;
        forever begin
            @(negedge clk);
            if (refclk_en && !p_clk) rise_clk = cyc;
            if (!refclk_en && p_clk) fall_clk = cyc;
            if (por_rst_n && !p_por) rise_por = cyc;
            if (!por_rst_n && p_por) fall_por = cyc;
            if (cfg_wr_req && !p_req) begin
                rise_req = cyc; cfg_cnt++;
                cap_port = cfg_wr_port; cap_addr = cfg_wr_addr;
                cap_data = cfg_wr_data; cap_utmi = utmi_rst_n;
            end
            if (!cfg_wr_req && p_req) fall_req = cyc;
            for (int p = 0; p < 2; p++) begin
                if (utmi_rst_n[p] && !p_utmi[p]) rise_utmi[p] = cyc;
                if (!utmi_rst_n[p] && p_utmi[p]) fall_utmi[p] = cyc;
                if (port_ready[p] && !p_rdy[p])  rise_rdy[p]  = cyc;
            end
            p_clk = refclk_en; p_por = por_rst_n; p_req = cfg_wr_req;
            p_utmi = utmi_rst_n; p_rdy = port_ready;
        end
    end

    // Test-register port model: completes a write DONE_LAT cycles after the request.
    initial begin
        int wait_n;
        wait_n = 0;
        forever begin
            @(negedge clk);
            if (cfg_wr_req && !cfg_wr_done) begin
                wait_n++;
                if (wait_n >= DONE_LAT) begin
                    cfg_wr_done = 1'b1;
                    wait_n = 0;
                end
            end else begin
                cfg_wr_done = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic [1:0] ini, input logic [1:0] ext);
        @(negedge clk);
        init_req = ini; exit_req = ext;
        @(negedge clk);
        init_req = '0; exit_req = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_ready(input logic [1:0] mask);
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if ((port_ready & mask) == mask) return;
        end
    endtask

    task automatic t_reset();
        idle(3);
        chk(refclk_en == 0 && por_rst_n == 0 && cfg_wr_req == 0, "R1 shared outputs in reset",
            {refclk_en, por_rst_n, cfg_wr_req}, 0);
        chk(utmi_rst_n == 0 && port_ready == 0, "R1 port outputs in reset",
            {utmi_rst_n, port_ready}, 0);
        rst_n = 1'b1;
        idle(5);
        chk(refclk_en == 0 && por_rst_n == 0 && utmi_rst_n == 0 && port_ready == 0,
            "R1 idle after reset", {refclk_en, por_rst_n, utmi_rst_n, port_ready}, 0);
    endtask

    task automatic t_cold_p0();
        pulse(2'b01, 2'b00);
        wait_ready(2'b01);
        idle(2);
        chk(rise_por - rise_clk == T_REF, "R2 clock to por delay", rise_por - rise_clk, T_REF);
        chk(rise_req - rise_por == T_POR, "R3 por to write delay", rise_req - rise_por, T_POR);
        chk(cap_port == 0 && cap_addr == 8'h06 && cap_data == 8'h04, "R3 write fields",
            {cap_port, cap_addr, cap_data}, {3'd0, 8'h06, 8'h04});
        chk(cap_utmi == 2'b00, "R3 utmi held during write", cap_utmi, 0);
        chk(fall_req - rise_req == DONE_LAT, "R4 request held until done",
            fall_req - rise_req, DONE_LAT);
        chk(rise_utmi[0] - fall_req == T_PHY, "R4 phy clock settle", rise_utmi[0] - fall_req, T_PHY);
        chk(rise_rdy[0] - rise_utmi[0] == T_UTMI, "R5 utmi settle", rise_rdy[0] - rise_utmi[0], T_UTMI);
        chk(utmi_rst_n == 2'b01 && port_ready == 2'b01, "R5 only port 0 released",
            {utmi_rst_n, port_ready}, 4'b0101);
        chk(cfg_cnt == 1, "R3 single config write", cfg_cnt, 1);
    endtask

    task automatic t_warm_p1();
        int c0, n0;
        n0 = cfg_cnt;
        c0 = cyc;
        pulse(2'b10, 2'b00);
        wait_ready(2'b10);
        idle(2);
        chk(rise_utmi[1] - c0 <= 3, "R6 fast utmi release", rise_utmi[1] - c0, 3);
        chk(cfg_cnt == n0, "R6 no config write", cfg_cnt, n0);
        chk(rise_rdy[1] - rise_utmi[1] == T_UTMI, "R6 ready delay", rise_rdy[1] - rise_utmi[1], T_UTMI);
        chk(refclk_en && por_rst_n, "R6 shared stays up", {refclk_en, por_rst_n}, 3);
    endtask

    task automatic t_ignore_init();
        int n0;
        n0 = cfg_cnt;
        pulse(2'b01, 2'b00);
        idle(50);
        chk(utmi_rst_n == 2'b11 && port_ready == 2'b11 && refclk_en && por_rst_n,
            "R10 init on ready port ignored", {utmi_rst_n, port_ready}, 4'b1111);
        chk(cfg_cnt == n0, "R10 no extra write", cfg_cnt, n0);
    endtask

    task automatic t_exit_shared();
        pulse(2'b00, 2'b01);
        idle(10);
        chk(utmi_rst_n == 2'b10 && port_ready == 2'b10, "R7 port 0 down",
            {utmi_rst_n, port_ready}, 4'b1010);
        chk(refclk_en && por_rst_n, "R7 shared kept", {refclk_en, por_rst_n}, 3);
    endtask

    task automatic t_exit_last();
        pulse(2'b00, 2'b10);
        idle(10);
        chk(utmi_rst_n == 0 && port_ready == 0 && !por_rst_n && !refclk_en, "R8 all down",
            {refclk_en, por_rst_n, utmi_rst_n, port_ready}, 0);
        chk(fall_por - fall_utmi[1] == 1, "R8 por after utmi", fall_por - fall_utmi[1], 1);
        chk(fall_clk - fall_por == 1, "R8 clock after por", fall_clk - fall_por, 1);
    endtask

    task automatic t_ignore_exit();
        pulse(2'b00, 2'b01);
        idle(20);
        chk(!refclk_en && !por_rst_n && utmi_rst_n == 0 && port_ready == 0,
            "R10 exit on idle port ignored", {refclk_en, por_rst_n, utmi_rst_n, port_ready}, 0);
    endtask

    task automatic t_queued();
        int n0;
        n0 = cfg_cnt;
        pulse(2'b11, 2'b00);
        wait_ready(2'b11);
        idle(2);
        chk(rise_utmi[0] < rise_utmi[1], "R9 port 0 served first", rise_utmi[0], rise_utmi[1]);
        chk(rise_utmi[1] - rise_rdy[0] == 1, "R9 held request served on idle",
            rise_utmi[1] - rise_rdy[0], 1);
        chk(cfg_cnt == n0 + 1, "R9 one write for both ports", cfg_cnt, n0 + 1);
        chk(port_ready == 2'b11, "R9 both ready", port_ready, 3);
    endtask

    initial begin
        wait (cyc == 150000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_cold_p0();
        t_warm_p1();
        t_ignore_init();
        t_exit_shared();
        t_exit_last();
        t_ignore_exit();
        t_queued();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule